// File: doc/BRIEF.md
# MMU Domain Check and Fault Status

This unit sits beside an address-translation path and holds the per-domain access policy plus two fault status registers, one for data-side and one for instruction-side accesses. For every access the translation path presents a 4-bit domain number, the result of the descriptor permission check, and flags for misalignment and external abort. From this the unit raises a domain fault or a permission fault in the same cycle. On the following clock edge it records the highest-priority fault, with the domain number, in the status register for the access side.

Software reaches all three registers through a register-access port. The port carries a register number, a secondary opcode, a write strobe and write data. Reads are combinational. Register numbers and opcodes that map to no register read as zero, and writes to them have no effect.

Top module: `mmu_domain_fault_unit`

## Requirements
- R1: On a clock edge with `rst_n` low, the domain policy register and both fault status registers become zero, and all three read back as zero.
- R2: Register number 3 with secondary opcode 0 reads and writes the 32-bit domain policy register. The field for domain n occupies bits 2n+1:2n.
- R3: With `mmu_en` high and a valid access, a domain field of 00 (no access) or 10 (reserved) raises `domain_fault` and never raises `perm_fault`, whatever `acc_perm_ok` is.
- R4: With `mmu_en` high and a valid access, a domain field of 01 (client) raises `perm_fault` exactly when `acc_perm_ok` is low, and never raises `domain_fault`.
- R5: With `mmu_en` high and a valid access, a domain field of 11 (manager) raises neither `domain_fault` nor `perm_fault`, whatever `acc_perm_ok` is.
- R6: While `mmu_en` is low, `domain_fault` and `perm_fault` stay low, and neither fault is recorded.
- R7: A fault status register holds the fault type in bits 3:0 and the domain number in bits 7:4, and bits 31:8 read zero. The fault type codes are alignment 0001, domain 1001, permission 1101 and external abort 1000. When several faults apply, the order of priority is alignment, then domain, then permission, then external abort. The recorded value appears one clock edge after the access.
- R8: An alignment error or an external abort on a valid access is recorded even while `mmu_en` is low.
- R9: An access with `acc_is_instr` low updates only the data status register (register number 5, opcode 0). An access with `acc_is_instr` high updates only the instruction status register (register number 5, opcode 1).
- R10: A software write to a fault status register stores write data bits 7:0. It takes priority over a fault recorded in the same cycle.
- R11: Register number 4 reads as zero and ignores writes. Any other unmapped combination of register number and opcode also reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_num | input | 4 | Register number |
| reg_op2 | input | 3 | Secondary opcode |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| mmu_en | input | 1 | Enables domain and permission checking |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_is_instr | input | 1 | 1 = instruction-side access, 0 = data-side access |
| acc_domain | input | 4 | Domain number of the access |
| acc_perm_ok | input | 1 | Descriptor permission check passed |
| acc_align_err | input | 1 | The access is misaligned |
| acc_ext_abort | input | 1 | External abort on the access |
| domain_fault | output | 1 | Domain fault for the current access |
| perm_fault | output | 1 | Permission fault for the current access |

## Verification
The policy register is loaded with four rotated patterns, so every domain is tried with every encoding. Each domain is swept with both values of the permission result, both access sides and both values of the enable. Flipping the permission result tells client from manager. Flipping the enable tells suppressed checks apart from the recording of alignment and abort. A further sweep crosses alignment and abort with the domain encodings to check the priority order, and same-cycle collisions between software writes and faults check which source wins.

// File: rtl/mmu_dom_pkg.sv
// Package: shared encodings for the MMU domain check unit.
// Assumes 2-bit domain fields and 4-bit fault type codes.
package mmu_dom_pkg;
    typedef enum logic [1:0] {
        DOM_NONE    = 2'b00,
        DOM_CLIENT  = 2'b01,
        DOM_RSVD    = 2'b10,
        DOM_MANAGER = 2'b11
    } dom_mode_e;

    localparam int FT_W = 4;
    localparam logic [FT_W-1:0] FT_ALIGN  = 4'b0001;
    localparam logic [FT_W-1:0] FT_DOMAIN = 4'b1001;
    localparam logic [FT_W-1:0] FT_PERM   = 4'b1101;
    localparam logic [FT_W-1:0] FT_EXTABT = 4'b1000;

    localparam int REGNO_DOMAIN = 3;
    localparam int REGNO_RSVD   = 4;
    localparam int REGNO_FAULT  = 5;
    localparam int OP2_DATA     = 0;
    localparam int OP2_INSTR    = 1;
    localparam int NUM_SIDES    = 2;
endpackage

// File: rtl/dom_field_select.sv
// Module: dom_field_select
// Picks the 2-bit policy field of the addressed domain out of the packed
// policy register. Assumes NUM_DOM is a power of two.
module dom_field_select
    import mmu_dom_pkg::*;
#(
    parameter int NUM_DOM = 16,
    localparam int DOM_W  = $clog2(NUM_DOM),
    localparam int DAC_W  = 2 * NUM_DOM
) (
    input  logic [DAC_W-1:0] dac,
    input  logic [DOM_W-1:0] dom,
    output dom_mode_e        mode
);
    logic [1:0] fields [NUM_DOM];

    // Split the packed register into one field per domain.
    for (genvar g = 0; g < NUM_DOM; g++) begin : g_field
        assign fields[g] = dac[2*g +: 2];
    end

    // Select the field of the current domain.
    always_comb begin
        mode = dom_mode_e'(fields[dom]);
    end
endmodule

// File: rtl/dom_access_judge.sv
// Module: dom_access_judge
// Classifies one access from its domain mode, permission result and error
// flags. Produces the fault outputs and the single prioritized fault code.
// Assumes the domain and permission checks apply only while mmu_en is high.
module dom_access_judge
    import mmu_dom_pkg::*;
(
    input  logic            acc_valid,
    input  logic            mmu_en,
    input  dom_mode_e       mode,
    input  logic            perm_ok,
    input  logic            align_err,
    input  logic            ext_abort,
    output logic            dom_fault,
    output logic            perm_fault,
    output logic            fault_hit,
    output logic [FT_W-1:0] fault_type
);
    // Domain and permission decisions; reserved behaves as no access.
    always_comb begin
        dom_fault  = acc_valid && mmu_en &&
                     ((mode == DOM_NONE) || (mode == DOM_RSVD));
        perm_fault = acc_valid && mmu_en && (mode == DOM_CLIENT) && !perm_ok;
    end

    // Pick the fault to record: alignment, domain, permission, abort.
    always_comb begin
        fault_hit  = 1'b1;
        fault_type = '0;
        if (!acc_valid) begin
            fault_hit = 1'b0;
        end else if (align_err) begin
            fault_type = FT_ALIGN;
        end else if (dom_fault) begin
            fault_type = FT_DOMAIN;
        end else if (perm_fault) begin
            fault_type = FT_PERM;
        end else if (ext_abort) begin
            fault_type = FT_EXTABT;
        end else begin
            fault_hit = 1'b0;
        end
    end
endmodule

// File: rtl/fault_status_bank.sv
// Module: fault_status_bank
// Holds one fault status register per access side (data, instruction).
// A software write to a side beats a hardware capture in the same cycle.
// Assumes synchronous active-low reset.
module fault_status_bank
    import mmu_dom_pkg::*;
#(
    parameter int DOM_W  = 4,
    localparam int FSR_W = FT_W + DOM_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_SIDES-1:0]            sw_wr,
    input  logic [FSR_W-1:0]                sw_data,
    input  logic                            hw_hit,
    input  logic                            hw_side,
    input  logic [FT_W-1:0]                 hw_type,
    input  logic [DOM_W-1:0]                hw_dom,
    output logic [NUM_SIDES-1:0][FSR_W-1:0] fsr_q
);
    for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
        // Update this side: reset, software write, then fault capture.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fsr_q[g] <= '0;
            end else if (sw_wr[g]) begin
                fsr_q[g] <= sw_data;
            end else if (hw_hit && (hw_side == 1'(g))) begin
                fsr_q[g] <= {hw_dom, hw_type};
            end
        end
    end
endmodule

// File: rtl/mmu_domain_fault_unit.sv
// Module: mmu_domain_fault_unit (top)
// Domain policy register, per-access domain/permission check and the data
// and instruction fault status registers behind a register-access port.
// Assumes one access per cycle, combinational reads, synchronous active-low reset.
module mmu_domain_fault_unit
    import mmu_dom_pkg::*;
#(
    parameter int NUM_DOM = 16,
    parameter int REG_W   = 4,
    parameter int OP2_W   = 3,
    parameter int DATA_W  = 32,
    localparam int DOM_W  = $clog2(NUM_DOM),
    localparam int DAC_W  = 2 * NUM_DOM,
    localparam int FSR_W  = FT_W + DOM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [REG_W-1:0]  reg_num,
    input  logic [OP2_W-1:0]  reg_op2,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              mmu_en,
    input  logic              acc_valid,
    input  logic              acc_is_instr,
    input  logic [DOM_W-1:0]  acc_domain,
    input  logic              acc_perm_ok,
    input  logic              acc_align_err,
    input  logic              acc_ext_abort,
    output logic              domain_fault,
    output logic              perm_fault
);
    logic [DAC_W-1:0]                 dacr_q;
    logic [NUM_SIDES-1:0][FSR_W-1:0]  fsr_all;
    logic [FSR_W-1:0]                 dfsr_q;
    logic [FSR_W-1:0]                 ifsr_q;
    logic                             sel_dac;
    logic [NUM_SIDES-1:0]             sel_fsr;
    dom_mode_e                        cur_mode;
    logic                             fault_hit;
    logic [FT_W-1:0]                  fault_type;

    // Decode which register the access port addresses.
    always_comb begin
        sel_dac    = (reg_num == REG_W'(REGNO_DOMAIN)) && (reg_op2 == OP2_W'(0));
        sel_fsr[0] = (reg_num == REG_W'(REGNO_FAULT)) && (reg_op2 == OP2_W'(OP2_DATA));
        sel_fsr[1] = (reg_num == REG_W'(REGNO_FAULT)) && (reg_op2 == OP2_W'(OP2_INSTR));
    end

    // Domain policy register, written by software only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dacr_q <= '0;
        end else if (reg_wr_en && sel_dac) begin
            dacr_q <= reg_wdata[DAC_W-1:0];
        end
    end

    dom_field_select #(.NUM_DOM(NUM_DOM)) u_sel (
        .dac  (dacr_q),
        .dom  (acc_domain),
        .mode (cur_mode)
    );

    dom_access_judge u_judge (
        .acc_valid  (acc_valid),
        .mmu_en     (mmu_en),
        .mode       (cur_mode),
        .perm_ok    (acc_perm_ok),
        .align_err  (acc_align_err),
        .ext_abort  (acc_ext_abort),
        .dom_fault  (domain_fault),
        .perm_fault (perm_fault),
        .fault_hit  (fault_hit),
        .fault_type (fault_type)
    );

    fault_status_bank #(.DOM_W(DOM_W)) u_fsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_wr   (sel_fsr & {NUM_SIDES{reg_wr_en}}),
        .sw_data (reg_wdata[FSR_W-1:0]),
        .hw_hit  (fault_hit),
        .hw_side (acc_is_instr),
        .hw_type (fault_type),
        .hw_dom  (acc_domain),
        .fsr_q   (fsr_all)
    );

    // Name the two status registers for the read mux and the checker.
    always_comb begin
        dfsr_q = fsr_all[0];
        ifsr_q = fsr_all[1];
    end

    // Read mux; unmapped numbers, including the reserved one, read zero.
    always_comb begin
        reg_rdata = '0;
        if (sel_dac) begin
            reg_rdata = DATA_W'(dacr_q);
        end else if (sel_fsr[0]) begin
            reg_rdata = DATA_W'(dfsr_q);
        end else if (sel_fsr[1]) begin
            reg_rdata = DATA_W'(ifsr_q);
        end
    end
endmodule

// File: rtl/mmu_domain_fault_chk.sv
// Module: mmu_domain_fault_chk
// Property checker bound to mmu_domain_fault_unit. Observes ports and the
// three architectural registers.
module mmu_domain_fault_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr_en,
    input logic [3:0]  reg_num,
    input logic [2:0]  reg_op2,
    input logic [7:0]  wdata_lo,
    input logic [31:0] reg_rdata,
    input logic        mmu_en,
    input logic        acc_valid,
    input logic        acc_is_instr,
    input logic [3:0]  acc_domain,
    input logic        domain_fault,
    input logic        perm_fault,
    input logic [31:0] dacr_q,
    input logic [7:0]  dfsr_q,
    input logic [7:0]  ifsr_q
);
    logic [1:0] enc;
    logic       wr_dfsr;
    logic       wr_ifsr;

    // Observe the policy field of the current domain and the write targets.
    always_comb begin
        enc     = dacr_q[{acc_domain, 1'b0} +: 2];
        wr_dfsr = reg_wr_en && (reg_num == 4'd5) && (reg_op2 == 3'd0);
        wr_ifsr = reg_wr_en && (reg_num == 4'd5) && (reg_op2 == 3'd1);
    end

    AST_NOACCESS_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && mmu_en && !enc[0]) |-> (domain_fault && !perm_fault)); // R3
    AST_CLIENT_NO_DOMAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && enc == 2'b01) |-> !domain_fault); // R4
    AST_MANAGER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (enc == 2'b11) |-> (!domain_fault && !perm_fault)); // R5
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !mmu_en |-> (!domain_fault && !perm_fault)); // R6
    AST_DATA_SIDE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_is_instr && !wr_ifsr) |=> $stable(ifsr_q)); // R9
    AST_INSTR_SIDE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_is_instr && !wr_dfsr) |=> $stable(dfsr_q)); // R9
    AST_SW_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dfsr |=> (dfsr_q == $past(wdata_lo))); // R10
    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_num == 4'd4) |-> (reg_rdata == 32'd0)); // R11
    AST_RSVD_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_num == 4'd4) |=> $stable(dacr_q)); // R11
endmodule

bind mmu_domain_fault_unit mmu_domain_fault_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr_en    (reg_wr_en),
    .reg_num      (reg_num),
    .reg_op2      (reg_op2),
    .wdata_lo     (reg_wdata[7:0]),
    .reg_rdata    (reg_rdata),
    .mmu_en       (mmu_en),
    .acc_valid    (acc_valid),
    .acc_is_instr (acc_is_instr),
    .acc_domain   (acc_domain),
    .domain_fault (domain_fault),
    .perm_fault   (perm_fault),
    .dacr_q       (dacr_q),
    .dfsr_q       (dfsr_q),
    .ifsr_q       (ifsr_q)
);

// File: tb/mmu_domain_fault_unit_bench.sv
// Bench: sweeps every domain through every policy encoding and checks
// fault outputs and status registers against an arithmetic model.
module mmu_domain_fault_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_num = '0;
    logic [2:0]  reg_op2 = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mmu_en = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_is_instr = 1'b0;
    logic [3:0]  acc_domain = '0;
    logic        acc_perm_ok = 1'b0;
    logic        acc_align_err = 1'b0;
    logic        acc_ext_abort = 1'b0;
    logic        domain_fault;
    logic        perm_fault;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [31:0] dacr_m = '0;
    logic [31:0] dfsr_m = '0;
    logic [31:0] ifsr_m = '0;

    always #5 clk = ~clk;

    mmu_domain_fault_unit u_mmu_domain_fault_unit (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] num, input logic [2:0] op2, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_num = num; reg_op2 = op2; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] num, input logic [2:0] op2, output logic [31:0] d);
        reg_num = num; reg_op2 = op2;
        #1 d = reg_rdata;
    endtask

    // One access; checks the fault outputs, then both status registers.
    task automatic access(input bit side, input int dom, input bit pok,
                          input bit al, input bit ab, input bit en);
        logic [1:0]  enc;
        bit          ed, ep, hit;
        logic [3:0]  code;
        logic [31:0] rd;
        string       tag;
        enc = 2'(dacr_m >> (2 * dom));
        ed  = en && (enc == 2'b00 || enc == 2'b10);
        ep  = en && (enc == 2'b01) && !pok;
        tag = !en ? "R6" : (enc == 2'b01) ? "R4" : (enc == 2'b11) ? "R5" : "R3";
        hit = 1'b1;
        if (al)      code = 4'b0001;
        else if (ed) code = 4'b1001;
        else if (ep) code = 4'b1101;
        else if (ab) code = 4'b1000;
        else begin code = 4'b0000; hit = 1'b0; end
        @(negedge clk);
        acc_valid = 1'b1; acc_is_instr = side; acc_domain = 4'(dom);
        acc_perm_ok = pok; acc_align_err = al; acc_ext_abort = ab; mmu_en = en;
        #1;
        check({tag, " domain_fault"}, 32'(domain_fault), 32'(ed));
        check({tag, " perm_fault"}, 32'(perm_fault), 32'(ep));
        @(negedge clk);
        acc_valid = 1'b0; acc_align_err = 1'b0; acc_ext_abort = 1'b0;
        if (hit) begin
            if (side) ifsr_m = {24'd0, 4'(dom), code};
            else      dfsr_m = {24'd0, 4'(dom), code};
        end
        tag = (!en && hit) ? "R8" : "R7";
        reg_read(4'd5, 3'd0, rd);
        check({tag, "/R9 data fsr"}, rd, dfsr_m);
        reg_read(4'd5, 3'd1, rd);
        check({tag, "/R9 instr fsr"}, rd, ifsr_m);
    endtask

    initial begin
        logic [31:0] rd;
        // R1: reset clears everything, also after registers were written.
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        reg_write(4'd3, 3'd0, 32'hDEAD_BEEF);
        reg_write(4'd5, 3'd0, 32'h0000_00AA);
        reg_write(4'd5, 3'd1, 32'h0000_0055);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        reg_read(4'd3, 3'd0, rd); check("R1 domain reg", rd, 32'd0);
        reg_read(4'd5, 3'd0, rd); check("R1 data fsr", rd, 32'd0);
        reg_read(4'd5, 3'd1, rd); check("R1 instr fsr", rd, 32'd0);

        // R2..R9: rotated policy patterns, full sweep of domains.
        for (int rot = 0; rot < 4; rot++) begin
            dacr_m = '0;
            for (int n = 0; n < 16; n++) dacr_m[2*n +: 2] = 2'((n + rot) % 4);
            reg_write(4'd3, 3'd0, dacr_m);
            reg_read(4'd3, 3'd0, rd);
            check("R2 domain reg readback", rd, dacr_m);
            for (int dom = 0; dom < 16; dom++)
                for (int s = 0; s < 2; s++)
                    for (int p = 0; p < 2; p++)
                        for (int e = 0; e < 2; e++)
                            access(s[0], dom, p[0], 1'b0, 1'b0, e[0]);
        end

        // R7/R8: alignment and abort crossed with encodings and enable.
        for (int dom = 0; dom < 4; dom++)
            for (int a = 0; a < 4; a++)
                for (int e = 0; e < 2; e++)
                    for (int s = 0; s < 2; s++)
                        access(s[0], dom, 1'b0, a[0], a[1], e[0]);

        // R10: software write collides with a data-side fault.
        @(negedge clk);
        mmu_en = 1'b1; acc_valid = 1'b1; acc_is_instr = 1'b0; acc_domain = 4'd0;
        acc_align_err = 1'b1;
        reg_wr_en = 1'b1; reg_num = 4'd5; reg_op2 = 3'd0; reg_wdata = 32'h1234_56A5;
        @(negedge clk);
        reg_wr_en = 1'b0; acc_valid = 1'b0; acc_align_err = 1'b0;
        reg_read(4'd5, 3'd0, rd); check("R10 write beats data fault", rd, 32'h0000_00A5);
        // R10: software write collides with an instruction-side fault.
        @(negedge clk);
        acc_valid = 1'b1; acc_is_instr = 1'b1; acc_ext_abort = 1'b1;
        reg_wr_en = 1'b1; reg_num = 4'd5; reg_op2 = 3'd1; reg_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        reg_wr_en = 1'b0; acc_valid = 1'b0; acc_ext_abort = 1'b0;
        reg_read(4'd5, 3'd1, rd); check("R10 write beats instr fault", rd, 32'h0000_00FF);

        // R11: reserved register and unmapped combinations.
        reg_write(4'd4, 3'd0, 32'h5A5A_5A5A);
        reg_read(4'd4, 3'd0, rd); check("R11 reg4 reads zero", rd, 32'd0);
        reg_read(4'd3, 3'd0, rd); check("R11 reg4 write ignored", rd, dacr_m);
        reg_read(4'd3, 3'd1, rd); check("R11 reg3 op2=1 zero", rd, 32'd0);
        reg_read(4'd5, 3'd2, rd); check("R11 reg5 op2=2 zero", rd, 32'd0);
        reg_read(4'd7, 3'd0, rd); check("R11 reg7 zero", rd, 32'd0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule